// File: doc/BRIEF.md
# Tagged Sensor Sample FIFO

This block buffers sensor readings that arrive as sets of up to four values: three acceleration axes and an optional temperature. A strobe presents a whole set at once. The block then writes the set as separate 16-bit entries, one per clock cycle, in a fixed channel order. Each entry carries a 2-bit channel tag, two sign-extension bits and the 12-bit two's complement value.

A byte-wide read port returns each entry as two bytes, low byte first. An entry is released only after its high byte has been consumed. A level flag rises once the stored entry count reaches a programmed threshold.

Two capture modes are offered:
- **Stream mode** keeps the newest data by discarding the oldest entry when the buffer is full.
- **Triggered mode** keeps a circular history until a trigger strobe. It then takes a fixed number of further entries and freezes until the mode field is written to a different value.

Top module: `tagged_sample_fifo`

## Requirements
- R1: Each stored entry is `{tag[1:0], sign, sign, value[11:0]}`, where sign is value bit 11. The tags are 00 for X, 01 for Y, 10 for Z and 11 for temperature.
- R2: A `smp_valid` pulse is taken only while no earlier set is still being written. The set is latched and written over the following cycles, one entry per cycle, in the order X, Y, Z, then temperature. Temperature is included only if `temp_en` was high at the pulse.
- R3: `rd_data` shows the low byte (bits 7:0) of the oldest entry. A `rd_byte` pulse advances it to the high byte (bits 15:8). A second pulse removes the entry, so `count` falls by one only after the high byte is read.
- R4: While the FIFO is empty, `rd_data` is 0x00, and `rd_byte` pulses leave `count` and `empty` unchanged.
- R5: With mode 2'b10 (stream), a write into a full FIFO discards the oldest entry. `count` stays at DEPTH and the newest DEPTH entries are kept in order.
- R6: `watermark` is high exactly when `wm_level` is non-zero and `count >= wm_level`.
- R7: With mode 2'b11 (triggered), entries are kept circularly until a `trig` pulse. After the trigger, exactly `wm_level` further entries are accepted. All later writes are then ignored until `mode` takes a different value and returns to 2'b11.
- R8: Mode values 2'b00 and 2'b01 disable writes. Sample sets presented in these modes leave `count` unchanged.
- R9: Any change of `mode` returns the byte selector to the low byte of the current oldest entry.
- R10: `count` never exceeds DEPTH, changes by at most one per cycle, and `empty` is high exactly when `count` is zero.
- R11: After reset, `count` is 0, `empty` is 1, `watermark` is 0 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | New sample set strobe |
| smp_x | input | 12 | X-axis value |
| smp_y | input | 12 | Y-axis value |
| smp_z | input | 12 | Z-axis value |
| smp_t | input | 12 | Temperature value |
| temp_en | input | 1 | Store temperature with the set |
| mode | input | 2 | 10 stream, 11 triggered, others disabled |
| wm_level | input | CW | Watermark threshold and post-trigger length |
| trig | input | 1 | Activity event strobe |
| rd_byte | input | 1 | Consume the byte on `rd_data` |
| rd_data | output | 8 | Current read byte |
| count | output | CW | Stored entry count |
| watermark | output | 1 | Count has reached the threshold |
| empty | output | 1 | No entries stored |

## Verification
Sample sets mix positive, negative, maximum and minimum 12-bit values. This separates sign-extension errors and tag errors from byte-order errors.

Sets are sent with and without temperature. This shows whether the set length follows the enable latched at the strobe.

A run of more sets than the buffer holds, in stream mode, shows whether the oldest or the newest entry is dropped. A triggered run with history before the event, followed by surplus sets afterwards, shows whether the freeze comes after exactly the programmed number of entries and whether a mode rewrite re-arms capture.

// File: rtl/tagged_sample_fifo.sv
module tagged_sample_fifo #(
  parameter int DEPTH = 512,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [11:0]   smp_x,
  input  logic [11:0]   smp_y,
  input  logic [11:0]   smp_z,
  input  logic [11:0]   smp_t,
  input  logic          temp_en,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] wm_level,
  input  logic          trig,
  input  logic          rd_byte,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count,
  output logic          watermark,
  output logic          empty
);
  localparam logic [1:0] M_STREAM = 2'b10;
  localparam logic [1:0] M_TRIG   = 2'b11;
  typedef enum logic [1:0] {T_PRE, T_POST, T_DONE} tstate_t;

  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, post_cnt;
  logic          half, busy, lat_t;
  logic [1:0]    idx, mode_q;
  logic [11:0]   lx, ly, lz, lt, cur;
  tstate_t       tst;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    case (idx)
      2'd0:    cur = lx;
      2'd1:    cur = ly;
      2'd2:    cur = lz;
      default: cur = lt;
    endcase
  end

  wire        mode_chg = (mode != mode_q);
  wire [1:0]  last_idx = lat_t ? 2'd3 : 2'd2;
  wire [15:0] wentry   = {idx, {2{cur[11]}}, cur};
  wire        is_empty = (cnt == '0);
  wire        is_full  = (cnt == CW'(DEPTH));
  wire        allow    = (mode == M_STREAM) || (mode == M_TRIG && tst != T_DONE);
  wire        do_wr    = busy && allow;
  wire        do_rd    = rd_byte && !is_empty && half;
  wire        drop     = do_wr && is_full && !do_rd;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wentry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      lat_t <= 1'b0;
      lx    <= '0;
      ly    <= '0;
      lz    <= '0;
      lt    <= '0;
    end else if (!busy) begin
      if (smp_valid) begin
        busy  <= 1'b1;
        idx   <= '0;
        lat_t <= temp_en;
        lx    <= smp_x;
        ly    <= smp_y;
        lz    <= smp_z;
        lt    <= smp_t;
      end
    end else begin
      if (idx == last_idx) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= nxt(wptr);
      if (do_rd || drop) rptr <= nxt(rptr);
      case ({do_wr && !drop, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     half <= 1'b0;
    else if (mode_chg || drop)      half <= 1'b0;
    else if (rd_byte && !is_empty)  half <= ~half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      tst      <= T_PRE;
      post_cnt <= '0;
    end else begin
      mode_q <= mode;
      if (mode_chg) begin
        tst      <= T_PRE;
        post_cnt <= '0;
      end else if (mode == M_TRIG) begin
        case (tst)
          T_PRE:  if (trig) tst <= (wm_level == '0) ? T_DONE : T_POST;
          T_POST: if (do_wr) begin
                    post_cnt <= post_cnt + 1'b1;
                    if (post_cnt + 1'b1 >= wm_level) tst <= T_DONE;
                  end
          default: tst <= tst;
        endcase
      end
    end
  end

  assign rd_data   = is_empty ? 8'h00 : (half ? mem[rptr][15:8] : mem[rptr][7:0]);
  assign count     = cnt;
  assign empty     = is_empty;
  assign watermark = (wm_level != '0) && (cnt >= wm_level);
endmodule

// File: rtl/tagged_sample_fifo_chk.sv
module tagged_sample_fifo_chk #(
  parameter int DEPTH = 512,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          rd_byte,
  input logic [7:0]    rd_data,
  input logic [CW-1:0] count,
  input logic          empty
);
  // R10
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) <= int'($past(count)) + 1) && (int'(count) + 1 >= int'($past(count))));

  // R4
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> rd_data == 8'h00);

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && !rd_byte) |=> $stable(count));

  // R5
  stream_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && int'(count) == DEPTH && !rd_byte) |=> int'(count) == DEPTH);
endmodule

bind tagged_sample_fifo tagged_sample_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rd_byte(rd_byte),
  .rd_data(rd_data), .count(count), .empty(empty)
);

// File: tb/tb_tagged_sample_fifo.sv
module tb_tagged_sample_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, smp_valid = 0, temp_en = 0, trig = 0, rd_byte = 0;
  logic [11:0] smp_x = 0, smp_y = 0, smp_z = 0, smp_t = 0;
  logic [1:0] mode = 0;
  logic [CW-1:0] wm_level = 0;
  logic [7:0] rd_data;
  logic [CW-1:0] count;
  logic watermark, empty;

  int errors = 0, checks = 0;
  logic [15:0] exp_q[$];
  int tphase = 0, post_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_sample_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
    .smp_z(smp_z), .smp_t(smp_t), .temp_en(temp_en), .mode(mode), .wm_level(wm_level),
    .trig(trig), .rd_byte(rd_byte), .rd_data(rd_data), .count(count),
    .watermark(watermark), .empty(empty)
  );

  function automatic logic [15:0] mk(input logic [1:0] tag, input logic [11:0] v);
    return {tag, {2{v[11]}}, v};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_push(input logic [15:0] e);
    if (mode == 2'b10 || (mode == 2'b11 && tphase != 2)) begin
      if (exp_q.size() == DEPTH) void'(exp_q.pop_front());
      exp_q.push_back(e);
      if (mode == 2'b11 && tphase == 1) begin
        post_n++;
        if (post_n >= int'(wm_level)) tphase = 2;
      end
    end
  endtask

  task automatic send_set(input logic [11:0] x, input logic [11:0] y,
                          input logic [11:0] z, input logic [11:0] t);
    model_push(mk(2'b00, x));
    model_push(mk(2'b01, y));
    model_push(mk(2'b10, z));
    if (temp_en) model_push(mk(2'b11, t));
    @(negedge clk);
    smp_valid = 1; smp_x = x; smp_y = y; smp_z = z; smp_t = t;
    @(negedge clk);
    smp_valid = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_pulse();
    rd_byte = 1;
    @(negedge clk);
    rd_byte = 0;
  endtask

  task automatic pop_check(input string req);
    logic [15:0] e;
    e = exp_q.pop_front();
    chk(req, rd_data, e[7:0]);
    rd_pulse();
    chk(req, rd_data, e[15:8]);
    rd_pulse();
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) pop_check(req);
    chk(req, count, 0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    if (m != mode) begin tphase = 0; post_n = 0; end
    mode = m;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    chk("R11 count", count, 0);
    chk("R11 empty", empty, 1);
    chk("R11 watermark", watermark, 0);
    chk("R11 rd_data", rd_data, 0);

    set_mode(2'b10);
    temp_en = 1;
    send_set(12'h123, 12'h8F0, 12'h7FF, 12'h800);
    chk("R2 set with temperature", count, 4);
    e = exp_q.pop_front();
    chk("R1 low byte", rd_data, e[7:0]);
    rd_pulse();
    chk("R3 kept after low byte", count, 4);
    chk("R1 high byte", rd_data, e[15:8]);
    rd_pulse();
    chk("R3 freed after high byte", count, 3);
    drain("R1");

    // R4
    chk("R4 empty data", rd_data, 0);
    rd_pulse();
    chk("R4 count", count, 0);
    chk("R4 empty flag", empty, 1);
    chk("R4 data after read", rd_data, 0);

    temp_en = 0;
    send_set(12'hFFF, 12'h001, 12'hA5A, 12'h333);
    chk("R2 set without temperature", count, 3);
    drain("R2");

    wm_level = 6;
    send_set(12'h010, 12'h020, 12'h030, 12'h0);
    chk("R6 below level", watermark, 0);
    send_set(12'h040, 12'h850, 12'h060, 12'h0);
    chk("R6 at level", watermark, 1);
    wm_level = 7;
    #1;
    chk("R6 raised level", watermark, 0);
    wm_level = 0;
    drain("R6");

    set_mode(2'b00);
    send_set(12'h111, 12'h222, 12'h333, 12'h0);
    chk("R8 mode 00", count, 0);
    set_mode(2'b01);
    send_set(12'h444, 12'h555, 12'h666, 12'h0);
    chk("R8 mode 01", count, 0);

    set_mode(2'b10);
    temp_en = 1;
    for (int i = 0; i < 6; i++)
      send_set(12'(i * 16 + 1), 12'(12'h800 + i), 12'(i * 3), 12'(12'hF00 + i));
    chk("R5 full", count, DEPTH);
    drain("R5");

    send_set(12'h2A5, 12'h3C3, 12'h444, 12'h555);
    e = exp_q[0];
    rd_pulse();
    set_mode(2'b00);
    chk("R9 back to low byte", rd_data, e[7:0]);
    set_mode(2'b10);
    drain("R9");

    set_mode(2'b11);
    wm_level = 5;
    temp_en = 0;
    send_set(12'h101, 12'h102, 12'h103, 12'h0);
    send_set(12'h201, 12'h202, 12'h203, 12'h0);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
    tphase = 1; post_n = 0;
    for (int i = 0; i < 3; i++)
      send_set(12'(12'h300 + i), 12'(12'h900 + i), 12'(12'h500 + i), 12'h0);
    chk("R7 post-trigger length", count, 11);
    send_set(12'h777, 12'h778, 12'h779, 12'h0);
    chk("R7 frozen", count, 11);
    drain("R7");
    wm_level = 0;
    set_mode(2'b10);
    set_mode(2'b11);
    send_set(12'h0AA, 12'h0BB, 12'h0CC, 12'h0);
    chk("R7 re-armed", count, 3);
    drain("R7");

    finish_run();
  end
endmodule